// File: doc/BRIEF.md
# Dual-Issue Warp Scheduler

This block holds the warps that live on one processing core and, every cycle, names up to two of them to issue. Incoming thread blocks are admitted as a whole: the block's thread count is cut into groups of 32 consecutive thread IDs. Each group becomes a warp and takes a free warp slot. If the last group is not full, that warp carries a lane mask that enables only its valid low lanes.

A warp may issue only while an external scoreboard reports its next instruction's operands as ready. Among those eligible warps, the block picks the warp from the oldest admitted block first and, inside one block, the lower slot number first. A second, different warp is picked by the same rule. Issue is combinational from the slot state and the ready flags, so a different warp can go out on every cycle with no switch penalty. When the execution side reports a warp finished, that warp is masked from issue at once and its slot is free from the next cycle.

Top module: `warp_issue_sched`

## Requirements
- R1: After synchronous active-low reset, no slot is occupied: no warp issues even with every operand-ready flag high, and an admit of 1024 threads sees `adm_ready` high.
- R2: An accepted admit of T threads (1 to 1024) creates ceil(T/32) warps. They occupy the lowest-numbered free slots, with warp 0 of the block (threads 0 to 31) in the lowest of them and thread IDs rising with slot number. They are eligible from the cycle after the admit.
- R3: The issue lane mask of a full warp is all 32 ones. The final warp of a block whose T is not a multiple of 32 has only bits 0 to (T mod 32)-1 set.
- R4: A slot issues only if it is occupied and its `opnd_rdy` bit is high in that cycle.
- R5: Priority is oldest admitted block first. Within one block, lower slot number first. Slot number does not outrank age across blocks.
- R6: Port 0 carries the highest-priority eligible warp and port 1 the next one. The two are always distinct. Port 1 is valid only when port 0 is valid.
- R7: Issue reacts within the same cycle to the ready flags, so different warps may issue on consecutive cycles with no idle cycle between them.
- R8: `adm_ready` is high only when the free slot count is at least ceil(T/32). An admit presented while it is low changes no state.
- R9: A warp reported on `fin_valid`/`fin_warp` is not issued in that cycle and never again. Its slot is free for a new admit from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adm_valid | input | 1 | Block admit request |
| adm_ready | output | 1 | Enough free slots for the presented block |
| adm_blk | input | 3 | Block slot of the admitted block (must not be in use) |
| adm_threads | input | 11 | Thread count of the block, 1 to 1024 |
| opnd_rdy | input | 48 | Per-slot operand-ready flags from the scoreboard |
| fin_valid | input | 1 | A warp has finished |
| fin_warp | input | 6 | Slot of the finished warp (must be occupied) |
| iss0_valid | output | 1 | Issue port 0 strobe |
| iss0_warp | output | 6 | Issue port 0 warp slot |
| iss0_mask | output | 32 | Issue port 0 lane mask |
| iss1_valid | output | 1 | Issue port 1 strobe |
| iss1_warp | output | 6 | Issue port 1 warp slot |
| iss1_mask | output | 32 | Issue port 1 lane mask |

## Verification
Both issue ports and `adm_ready` are combinational. They respond in the same cycle to `opnd_rdy`, `fin_valid` and `adm_threads`. An accepted admit or a finish changes slot state only at the next rising edge, so its effect is checked one cycle later. The bench drives each cycle's inputs 1 ns after the rising edge and pushes the expected outputs for that cycle into a queue. A monitor pops the queue and compares on the falling edge of the same cycle, after the combinational paths have settled and before the next edge updates state.

// File: rtl/wis_pkg.sv
// Shared constants and helpers for the warp issue scheduler.
// Assumes the warp width is fixed at 32 lanes.
package wis_pkg;
    localparam int WARP_LANES = 32;
    localparam int LOG_LANES  = 5;
    localparam int LANE_W     = LOG_LANES + 1;  // holds 1..32

    // Expand a lane count (1..32) into a mask of the low lanes.
    function automatic logic [WARP_LANES-1:0] lane_mask(input logic [LANE_W-1:0] cnt);
        logic [WARP_LANES:0] wide;
        wide = ((WARP_LANES+1)'(1) << cnt) - (WARP_LANES+1)'(1);
        return wide[WARP_LANES-1:0];
    endfunction
endpackage

// File: rtl/wis_alloc.sv
// Slot allocator: works out how many warps a block needs, whether they fit,
// and which free slots (lowest first) receive them, with each slot's lane count.
// Assumes THR_W is wide enough to hold NUM_SLOTS.
module wis_alloc
    import wis_pkg::*;
#(
    parameter int NUM_SLOTS = 48,
    parameter int THR_W     = 11
) (
    input  logic [NUM_SLOTS-1:0]             free_slots,
    input  logic [THR_W-1:0]                 threads,
    input  logic                             fire,
    output logic                             fits,
    output logic [NUM_SLOTS-1:0]             alloc,
    output logic [NUM_SLOTS-1:0][LANE_W-1:0] alloc_lanes
);
    localparam logic [THR_W-1:0] ONE_T = THR_W'(1);

    logic [THR_W-1:0] need;
    logic [THR_W-1:0] last_lanes;
    logic [THR_W-1:0] free_cnt;
    logic [THR_W-1:0] rank;

    // Warp count and size of the last warp of the block.
    always_comb begin
        need       = (threads + THR_W'(WARP_LANES - 1)) >> LOG_LANES;
        last_lanes = threads - ((need - ONE_T) << LOG_LANES);
    end

    // Walk the free slots in ascending order, handing out warp indices.
    always_comb begin
        rank     = '0;
        free_cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            alloc[i]       = 1'b0;
            alloc_lanes[i] = LANE_W'(WARP_LANES);
            if (free_slots[i]) begin
                free_cnt = free_cnt + ONE_T;
                if (fire && rank < need) begin
                    alloc[i] = 1'b1;
                    if (rank == need - ONE_T)
                        alloc_lanes[i] = LANE_W'(last_lanes);
                end
                rank = rank + ONE_T;
            end
        end
    end

    // The block is accepted only if all of its warps fit at once.
    assign fits = (need <= free_cnt);
endmodule

// File: rtl/wis_age.sv
// Block age tracker: a relation matrix where older[x][y] means block slot x
// was admitted before block slot y. Assumes an admitted block slot is not live.
module wis_age #(
    parameter int NUM_BLKS = 8,
    parameter int BLK_W    = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fire,
    input  logic [BLK_W-1:0]                   blk,
    output logic [NUM_BLKS-1:0][NUM_BLKS-1:0]  older
);
    // A new block becomes younger than every other block slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else if (fire) begin
            for (int x = 0; x < NUM_BLKS; x++) begin
                older[x][blk] <= (x != int'(blk));
                older[blk][x] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wis_pick.sv
// Priority picker: selects the oldest block holding an eligible warp, then
// the lowest eligible slot inside that block. Purely combinational.
module wis_pick #(
    parameter int NUM_SLOTS = 48,
    parameter int SLOT_W    = 6,
    parameter int NUM_BLKS  = 8,
    parameter int BLK_W     = 3
) (
    input  logic [NUM_SLOTS-1:0]              elig,
    input  logic [NUM_SLOTS-1:0][BLK_W-1:0]   slot_blk,
    input  logic [NUM_BLKS-1:0][NUM_BLKS-1:0] older,
    output logic                              pick_valid,
    output logic [SLOT_W-1:0]                 pick_idx
);
    logic [NUM_BLKS-1:0]  blk_has;
    logic [NUM_BLKS-1:0]  blk_sel;
    logic [NUM_SLOTS-1:0] cand;

    // Which block slots own at least one eligible warp.
    always_comb begin
        blk_has = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (elig[i]) blk_has[slot_blk[i]] = 1'b1;
    end

    // Keep the block that no other candidate block is older than.
    always_comb begin
        for (int b = 0; b < NUM_BLKS; b++) begin
            blk_sel[b] = blk_has[b];
            for (int c = 0; c < NUM_BLKS; c++)
                if (c != b && blk_has[c] && older[c][b]) blk_sel[b] = 1'b0;
        end
    end

    // Lowest eligible slot inside the chosen block.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cand[i] = elig[i] && blk_sel[slot_blk[i]];
            if (cand[i] && !pick_valid) begin
                pick_valid = 1'b1;
                pick_idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/warp_issue_sched.sv
// Dual-issue warp scheduler. Holds per-slot warp state (occupied, owning
// block slot, lane count), admits whole blocks, retires finished warps and
// issues up to two distinct eligible warps per cycle, oldest block first.
// Assumes fin_warp names an occupied slot and adm_blk names a free block slot.
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_SLOTS = 48,
    parameter int NUM_BLKS  = 8,
    parameter int THR_W     = 11,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int BLK_W    = $clog2(NUM_BLKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adm_valid,
    output logic                  adm_ready,
    input  logic [BLK_W-1:0]      adm_blk,
    input  logic [THR_W-1:0]      adm_threads,
    input  logic [NUM_SLOTS-1:0]  opnd_rdy,
    input  logic                  fin_valid,
    input  logic [SLOT_W-1:0]     fin_warp,
    output logic                  iss0_valid,
    output logic [SLOT_W-1:0]     iss0_warp,
    output logic [WARP_LANES-1:0] iss0_mask,
    output logic                  iss1_valid,
    output logic [SLOT_W-1:0]     iss1_warp,
    output logic [WARP_LANES-1:0] iss1_mask
);
    logic [NUM_SLOTS-1:0]              valid_q;
    logic [NUM_SLOTS-1:0][BLK_W-1:0]   blk_q;
    logic [NUM_SLOTS-1:0][LANE_W-1:0]  lanes_q;

    logic                              fits;
    logic                              fire;
    logic [NUM_SLOTS-1:0]              alloc;
    logic [NUM_SLOTS-1:0][LANE_W-1:0]  alloc_lanes;
    logic [NUM_BLKS-1:0][NUM_BLKS-1:0] older;
    logic [NUM_SLOTS-1:0]              fin_mask;
    logic [NUM_SLOTS-1:0]              elig0;
    logic [NUM_SLOTS-1:0]              elig1;

    assign adm_ready = fits;
    assign fire      = adm_valid && fits;

    wis_alloc #(.NUM_SLOTS(NUM_SLOTS), .THR_W(THR_W)) u_alloc (
        .free_slots (~valid_q),
        .threads    (adm_threads),
        .fire       (fire),
        .fits       (fits),
        .alloc      (alloc),
        .alloc_lanes(alloc_lanes)
    );

    wis_age #(.NUM_BLKS(NUM_BLKS), .BLK_W(BLK_W)) u_age (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (fire),
        .blk  (adm_blk),
        .older(older)
    );

    // Eligible: occupied, operands ready, and not finishing this cycle.
    always_comb begin
        fin_mask = fin_valid ? (NUM_SLOTS'(1) << fin_warp) : '0;
        elig0    = valid_q & opnd_rdy & ~fin_mask;
        elig1    = elig0 & ~(iss0_valid ? (NUM_SLOTS'(1) << iss0_warp) : '0);
    end

    wis_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .NUM_BLKS(NUM_BLKS), .BLK_W(BLK_W)) u_pick0 (
        .elig(elig0), .slot_blk(blk_q), .older(older),
        .pick_valid(iss0_valid), .pick_idx(iss0_warp)
    );

    wis_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .NUM_BLKS(NUM_BLKS), .BLK_W(BLK_W)) u_pick1 (
        .elig(elig1), .slot_blk(blk_q), .older(older),
        .pick_valid(iss1_valid), .pick_idx(iss1_warp)
    );

    // Lane masks of the two issued warps.
    assign iss0_mask = lane_mask(lanes_q[iss0_warp]);
    assign iss1_mask = lane_mask(lanes_q[iss1_warp]);

    // Slot state: fill on admit, release on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            blk_q   <= '0;
            lanes_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (alloc[i]) begin
                    valid_q[i] <= 1'b1;
                    blk_q[i]   <= adm_blk;
                    lanes_q[i] <= alloc_lanes[i];
                end else if (fin_mask[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/wis_chk.sv
// Property checker for warp_issue_sched, bound into every instance.
// Keeps its own occupancy count to judge admission.
module wis_chk #(
    parameter int NUM_SLOTS = 48,
    parameter int THR_W     = 11,
    parameter int SLOT_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adm_valid,
    input logic              adm_ready,
    input logic [THR_W-1:0]  adm_threads,
    input logic [NUM_SLOTS-1:0] opnd_rdy,
    input logic              fin_valid,
    input logic [SLOT_W-1:0] fin_warp,
    input logic              iss0_valid,
    input logic [SLOT_W-1:0] iss0_warp,
    input logic [31:0]       iss0_mask,
    input logic              iss1_valid,
    input logic [SLOT_W-1:0] iss1_warp,
    input logic [31:0]       iss1_mask
);
    logic [THR_W-1:0] occ;
    logic [THR_W-1:0] need;

    assign need = (adm_threads + THR_W'(31)) >> 5;

    // Independent occupancy count from admits and finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + ((adm_valid && adm_ready) ? need : '0)
                        - (fin_valid ? THR_W'(1) : '0);
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adm_valid && adm_ready) |-> (occ + need <= THR_W'(NUM_SLOTS)));

    assert_ready_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> opnd_rdy[iss0_warp]);

    assert_ready_flag1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> opnd_rdy[iss1_warp]);

    assert_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> (iss0_valid && iss1_warp != iss0_warp));

    assert_fin_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_valid |-> (!(iss0_valid && iss0_warp == fin_warp) &&
                       !(iss1_valid && iss1_warp == fin_warp)));

    assert_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> (iss0_mask[0] && ((iss0_mask & (iss0_mask + 32'd1)) == 32'd0)));

    assert_mask_shape1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> (iss1_mask[0] && ((iss1_mask & (iss1_mask + 32'd1)) == 32'd0)));
endmodule

bind warp_issue_sched wis_chk #(.NUM_SLOTS(NUM_SLOTS), .THR_W(THR_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .adm_valid(adm_valid), .adm_ready(adm_ready),
    .adm_threads(adm_threads), .opnd_rdy(opnd_rdy), .fin_valid(fin_valid),
    .fin_warp(fin_warp), .iss0_valid(iss0_valid), .iss0_warp(iss0_warp),
    .iss0_mask(iss0_mask), .iss1_valid(iss1_valid), .iss1_warp(iss1_warp),
    .iss1_mask(iss1_mask)
);

// File: tb/warp_issue_sched_tb.sv
// Scoreboard bench: the driver task applies one cycle of stimulus and queues
// the expected outputs; the monitor compares them on the falling edge.
module warp_issue_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adm_valid = 1'b0;
    logic        adm_ready;
    logic [2:0]  adm_blk = '0;
    logic [10:0] adm_threads = 11'd1;
    logic [47:0] opnd_rdy = '0;
    logic        fin_valid = 1'b0;
    logic [5:0]  fin_warp = '0;
    logic        iss0_valid, iss1_valid;
    logic [5:0]  iss0_warp, iss1_warp;
    logic [31:0] iss0_mask, iss1_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        bit          cr; bit er;
        bit          v0; logic [5:0] w0; logic [31:0] m0;
        bit          v1; logic [5:0] w1; logic [31:0] m1;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    localparam logic [31:0] FULL = 32'hFFFF_FFFF;

    always #5 clk = ~clk;

    warp_issue_sched u_dut (
        .clk(clk), .rst_n(rst_n), .adm_valid(adm_valid), .adm_ready(adm_ready),
        .adm_blk(adm_blk), .adm_threads(adm_threads), .opnd_rdy(opnd_rdy),
        .fin_valid(fin_valid), .fin_warp(fin_warp),
        .iss0_valid(iss0_valid), .iss0_warp(iss0_warp), .iss0_mask(iss0_mask),
        .iss1_valid(iss1_valid), .iss1_warp(iss1_warp), .iss1_mask(iss1_mask)
    );

    function automatic logic [47:0] bit_of(input int n);
        return 48'(1) << n;
    endfunction

    // Driver: apply one cycle of inputs and queue the expected outputs.
    task automatic step(input bit av, input int ab, input int at, input logic [47:0] rm,
                        input bit fv, input int fw, input bit cr, input bit er,
                        input bit v0, input int w0, input logic [31:0] m0,
                        input bit v1, input int w1, input logic [31:0] m1,
                        input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        adm_valid   = av;
        adm_blk     = 3'(ab);
        adm_threads = 11'(at);
        opnd_rdy    = rm;
        fin_valid   = fv;
        fin_warp    = 6'(fw);
        e = '{cr: cr, er: er, v0: v0, w0: 6'(w0), m0: m0, v1: v1, w1: 6'(w1), m1: m1};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs against the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            bit    bad;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            bad = (e.cr && adm_ready !== e.er) || (iss0_valid !== e.v0) ||
                  (e.v0 && (iss0_warp !== e.w0 || iss0_mask !== e.m0)) ||
                  (iss1_valid !== e.v1) ||
                  (e.v1 && (iss1_warp !== e.w1 || iss1_mask !== e.m1));
            n_tests++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: got rdy=%b p0=%b/%0d/%h p1=%b/%0d/%h exp rdy=%b p0=%b/%0d/%h p1=%b/%0d/%h",
                         t, adm_ready, iss0_valid, iss0_warp, iss0_mask,
                         iss1_valid, iss1_warp, iss1_mask, e.er, e.v0, e.w0, e.m0,
                         e.v1, e.w1, e.m1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no end, exp end of stimulus");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: empty after reset
        step(0,0,1024,'1,0,0, 1,1, 0,0,0, 0,0,0, "R1 reset empty");
        // R2: block 0, 70 threads -> slots 0,1,2 (last 6 lanes)
        step(1,0,70,'1,0,0, 1,1, 0,0,0, 0,0,0, "R2 admit accepted");
        step(0,0,1,'1,0,0, 0,0, 1,0,FULL, 1,1,FULL, "R2 R6 first two warps");
        step(0,0,1,bit_of(2),0,0, 0,0, 1,2,32'h3F, 0,0,0, "R3 R4 partial warp only");
        // block 5, 256 threads -> slots 3..10
        step(1,5,256,bit_of(1)|bit_of(2),0,0, 1,1, 1,1,FULL, 1,2,32'h3F, "R2 R6 admit while issuing");
        step(0,0,1,bit_of(0)|bit_of(3)|bit_of(4),0,0, 0,0, 1,0,FULL, 1,3,FULL, "R5 oldest block first");
        step(0,0,1,bit_of(3)|bit_of(4),0,0, 0,0, 1,3,FULL, 1,4,FULL, "R5 lower slot in block");
        step(0,0,1,bit_of(5)|bit_of(6),0,0, 0,0, 1,5,FULL, 1,6,FULL, "R7 back-to-back switch");
        step(0,0,1,bit_of(1)|bit_of(2),1,1, 0,0, 1,2,32'h3F, 0,0,0, "R9 finishing warp masked");
        step(0,0,1,bit_of(1)|bit_of(7),0,0, 0,0, 1,7,FULL, 0,0,0, "R9 finished warp gone");
        step(0,0,1,bit_of(10),0,0, 0,0, 1,10,FULL, 0,0,0, "R3 exact multiple full mask");
        // block 3, 1024 threads -> slots 1, 11..41
        step(1,3,1024,'0,0,0, 1,1, 0,0,0, 0,0,0, "R9 freed slot reusable");
        step(0,0,1,bit_of(1)|bit_of(8),0,0, 0,0, 1,8,FULL, 1,1,FULL, "R5 age beats slot number");
        step(0,0,1,bit_of(41),0,0, 0,0, 1,41,FULL, 0,0,0, "R2 last slot of big block");
        // 224 threads need 7 slots, only 6 free
        step(1,4,224,'0,0,0, 1,0, 0,0,0, 0,0,0, "R8 back-pressure");
        step(0,0,1,bit_of(42),0,0, 0,0, 0,0,0, 0,0,0, "R8 refused admit no effect");
        step(1,4,170,'0,0,0, 1,1, 0,0,0, 0,0,0, "R8 fitting admit accepted");
        step(0,0,1,bit_of(47)|bit_of(42),0,0, 0,0, 1,42,FULL, 1,47,32'h3FF, "R3 last partial warp");
        step(0,0,1,'1,0,0, 0,0, 1,0,FULL, 1,2,FULL & 32'h3F, "R5 R6 all ready");
        step(0,0,1,'1,1,0, 0,0, 1,2,32'h3F, 1,3,FULL, "R9 finish oldest");
        step(0,0,1,bit_of(0),0,0, 0,0, 0,0,0, 0,0,0, "R9 never issued again");
        @(posedge clk);
        #1;
        opnd_rdy  = '0;
        fin_valid = 1'b0;
        adm_valid = 1'b0;
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule